// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder

This block decodes a fixed-width instruction word whose opcode length varies with the number of address operands it carries. The word is made of four equal nibbles. A short opcode sits in the top nibble. When that nibble holds the all-ones escape value, the opcode grows into the next nibble, and so on down the word. Each step keeps some code points for its own instructions and leaves the rest as escapes for the next, longer step. The result is a prefix-free map: a word always belongs to exactly one instruction.

For each strobed word the decoder reports four things. First, the instruction class: three-, two-, one- or zero-address. Second, a number for the opcode that counts from zero within that class. Third, the address nibbles the instruction carries. Fourth, a valid flag. All of these appear on registers one clock after the strobe, and address outputs that a class does not use are forced to zero. The block does not execute instructions or resolve operands.

Top module: `xop_decoder`

## Requirements
- R1: A word whose top nibble [15:12] is 0..14 gives class code 0 (three-address). Its opcode number equals that nibble, and addr1/addr2/addr3 carry bits [11:8], [7:4] and [3:0].
- R2: A word with top nibble 15 and bits [11:8] in 0..11 gives class code 1 (two-address). Its opcode number equals bits [11:8], addr1 carries [7:4], addr2 carries [3:0] and addr3 is 0.
- R3: A word with top nibble 15 and bits [11:8] in 12..14 gives class code 2 (one-address). Its opcode number is (bits[11:8]-12)*16 + bits[7:4], so the values run 0..47. addr1 carries [3:0].
- R4: A word with bits [15:4] = 0xFF0..0xFFD gives class code 2. Its opcode number is 48 + bits[7:4], so the values run 48..61. addr1 carries [3:0].
- R5: A word with bits [15:5] all ones gives class code 3 (zero-address). Its opcode number is bit[4]*16 + bits[3:0], so the values run 0..31.
- R6: Address outputs that the decoded class does not use read 0. Two-address words have addr3 = 0. One-address words have addr2 = addr3 = 0. Zero-address words have all three address outputs at 0.
- R7: Outputs update on the clock edge after in_valid is sampled high. out_valid is high for exactly the cycles that follow a sampled strobe. While in_valid is low, the class, opcode and address outputs keep their last values.
- R8: While reset is asserted, out_valid, the class, the opcode and all address outputs are 0.
- R9: Across all 65536 words, the classes cover 61440, 3072, 992 and 32 words respectively. Every word decodes to the opcode and fields given by R1 to R6, so no two instructions share an encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| in_valid | input | 1 | Strobe: in_word is to be decoded |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result is fresh this cycle |
| out_cls | output | 2 | Class code: 0 three-, 1 two-, 2 one-, 3 zero-address |
| out_op | output | 6 | Opcode number within the class |
| out_a1 | output | 4 | First address field |
| out_a2 | output | 4 | Second address field |
| out_a3 | output | 4 | Third address field |

## Verification
The bench walks every one of the 65536 words. This exposes any boundary slip at an escape: if 0xF or 0xC were treated as a code point instead of an escape, or the reverse, whole ranges would land in the wrong class and the class tallies would be off. The bench also aims at the joins in the one-address numbering, at 47/48 and at 0xFFD against 0xFFE, where a wrong offset gives duplicate or skipped opcode numbers. It checks words with in_valid low and a changed input, where an enable that is missing leaks the new word onto the outputs. Further directed and seeded random words show whether address nibbles are taken from the wrong position or left unzeroed for short classes.

// File: rtl/xop_pkg.sv
package xop_pkg;
  typedef enum logic [1:0] {
    CLS_THREE = 2'd0,
    CLS_TWO   = 2'd1,
    CLS_ONE   = 2'd2,
    CLS_ZERO  = 2'd3
  } xop_cls_e;
endpackage

// File: rtl/xop_classify.sv
module xop_classify #(
  parameter int NIB_W = 4
) (
  input  logic [4*NIB_W-1:0] word,
  output xop_pkg::xop_cls_e  cls,
  output logic               grp_long
);
  import xop_pkg::*;
  localparam int          NSTATES = 2**NIB_W;
  localparam logic [NIB_W-1:0] ESC      = {NIB_W{1'b1}};
  localparam logic [NIB_W-1:0] TWO_LIM  = NIB_W'(NSTATES - 4);
  localparam logic [NIB_W-1:0] ONE_LIM  = NIB_W'(NSTATES - 2);

  logic [NIB_W-1:0] n3, n2, n1;
  assign n3 = word[4*NIB_W-1 -: NIB_W];
  assign n2 = word[3*NIB_W-1 -: NIB_W];
  assign n1 = word[2*NIB_W-1 -: NIB_W];

  always_comb begin
    cls      = CLS_ZERO;
    grp_long = 1'b0;
    if (n3 != ESC) begin
      cls = CLS_THREE;
    end else if (n2 < TWO_LIM) begin
      cls = CLS_TWO;
    end else if (n2 != ESC) begin
      cls = CLS_ONE;
    end else if (n1 < ONE_LIM) begin
      cls      = CLS_ONE;
      grp_long = 1'b1;
    end
  end
endmodule

// File: rtl/xop_fields.sv
module xop_fields #(
  parameter int NIB_W = 4,
  parameter int OP_W  = NIB_W + 2
) (
  input  logic [4*NIB_W-1:0] word,
  input  xop_pkg::xop_cls_e  cls,
  input  logic               grp_long,
  output logic [OP_W-1:0]    op,
  output logic [NIB_W-1:0]   a1,
  output logic [NIB_W-1:0]   a2,
  output logic [NIB_W-1:0]   a3
);
  import xop_pkg::*;
  localparam int NSTATES = 2**NIB_W;
  localparam logic [OP_W-1:0] TWO_LIM = OP_W'(NSTATES - 4);
  localparam logic [OP_W-1:0] ONE_LIM = OP_W'(NSTATES - 2);
  localparam logic [OP_W-1:0] LONG_BASE = OP_W'(3 * NSTATES);

  logic [NIB_W-1:0] nib [4];
  for (genvar g = 0; g < 4; g++) begin : g_nib
    assign nib[g] = word[g*NIB_W +: NIB_W];
  end

  logic [OP_W-1:0] w2, w1, w0;
  assign w2 = OP_W'(nib[2]);
  assign w1 = OP_W'(nib[1]);
  assign w0 = OP_W'(nib[0]);

  always_comb begin
    op = '0;
    a1 = '0;
    a2 = '0;
    a3 = '0;
    unique case (cls)
      CLS_THREE: begin
        op = OP_W'(nib[3]);
        a1 = nib[2];
        a2 = nib[1];
        a3 = nib[0];
      end
      CLS_TWO: begin
        op = w2;
        a1 = nib[1];
        a2 = nib[0];
      end
      CLS_ONE: begin
        if (grp_long) op = LONG_BASE + w1;
        else          op = ((w2 - TWO_LIM) << NIB_W) + w1;
        a1 = nib[0];
      end
      default: begin
        op = ((w1 - ONE_LIM) << NIB_W) + w0;
      end
    endcase
  end
endmodule

// File: rtl/xop_outreg.sv
module xop_outreg #(
  parameter int NIB_W = 4,
  parameter int OP_W  = NIB_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  xop_pkg::xop_cls_e cls_d,
  input  logic [OP_W-1:0]   op_d,
  input  logic [NIB_W-1:0]  a1_d,
  input  logic [NIB_W-1:0]  a2_d,
  input  logic [NIB_W-1:0]  a3_d,
  output logic              vld_q,
  output xop_pkg::xop_cls_e cls_q,
  output logic [OP_W-1:0]   op_q,
  output logic [NIB_W-1:0]  a1_q,
  output logic [NIB_W-1:0]  a2_q,
  output logic [NIB_W-1:0]  a3_q
);
  import xop_pkg::*;
  xop_cls_e        cls_n;
  logic [OP_W-1:0] op_n;
  logic [NIB_W-1:0] a1_n, a2_n, a3_n;

  always_comb begin
    cls_n = cls_q;
    op_n  = op_q;
    a1_n  = a1_q;
    a2_n  = a2_q;
    a3_n  = a3_q;
    if (en) begin
      cls_n = cls_d;
      op_n  = op_d;
      a1_n  = a1_d;
      a2_n  = a2_d;
      a3_n  = a3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cls_q <= CLS_THREE;
      op_q  <= '0;
      a1_q  <= '0;
      a2_q  <= '0;
      a3_q  <= '0;
    end else begin
      vld_q <= en;
      cls_q <= cls_n;
      op_q  <= op_n;
      a1_q  <= a1_n;
      a2_q  <= a2_n;
      a3_q  <= a3_n;
    end
  end

  // R7: valid tracks the strobe one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_q);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_q);
  // R7: held outputs when no strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cls_q) && $stable(op_q) && $stable(a1_q)
             && $stable(a2_q) && $stable(a3_q)));
endmodule

// File: rtl/xop_decoder.sv
module xop_decoder #(
  parameter int NIB_W = 4,
  parameter int OP_W  = NIB_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [4*NIB_W-1:0] in_word,
  output logic               out_valid,
  output logic [1:0]         out_cls,
  output logic [OP_W-1:0]    out_op,
  output logic [NIB_W-1:0]   out_a1,
  output logic [NIB_W-1:0]   out_a2,
  output logic [NIB_W-1:0]   out_a3
);
  import xop_pkg::*;
  localparam int NSTATES = 2**NIB_W;
  localparam int MAX_THREE = NSTATES - 2;
  localparam int MAX_TWO   = NSTATES - 5;
  localparam int MAX_ONE   = 4 * NSTATES - 3;
  localparam int MAX_ZERO  = 2 * NSTATES - 1;

  xop_cls_e        cls_c, cls_r;
  logic            grp_long_c;
  logic [OP_W-1:0] op_c;
  logic [NIB_W-1:0] a1_c, a2_c, a3_c;

  xop_classify #(.NIB_W(NIB_W)) u_classify (
    .word     (in_word),
    .cls      (cls_c),
    .grp_long (grp_long_c)
  );

  xop_fields #(.NIB_W(NIB_W), .OP_W(OP_W)) u_fields (
    .word     (in_word),
    .cls      (cls_c),
    .grp_long (grp_long_c),
    .op       (op_c),
    .a1       (a1_c),
    .a2       (a2_c),
    .a3       (a3_c)
  );

  xop_outreg #(.NIB_W(NIB_W), .OP_W(OP_W)) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .cls_d (cls_c),
    .op_d  (op_c),
    .a1_d  (a1_c),
    .a2_d  (a2_c),
    .a3_d  (a3_c),
    .vld_q (out_valid),
    .cls_q (cls_r),
    .op_q  (out_op),
    .a1_q  (out_a1),
    .a2_q  (out_a2),
    .a3_q  (out_a3)
  );

  assign out_cls = cls_r;

  // R1: three-address opcode never reaches the escape value
  a_r1_three_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cls == CLS_THREE) |-> (int'(out_op) <= MAX_THREE));
  // R2: two-address opcode stays below the reserved escapes
  a_r2_two_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cls == CLS_TWO) |-> (int'(out_op) <= MAX_TWO));
  // R4: one-address numbering tops out below the zero-address escapes
  a_r4_one_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cls == CLS_ONE) |-> (int'(out_op) <= MAX_ONE));
  // R5: zero-address numbering range
  a_r5_zero_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cls == CLS_ZERO) |-> (int'(out_op) <= MAX_ZERO));
  // R6: unused address outputs are zero
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_cls == CLS_THREE) ||
                   (out_a3 == '0 && (out_cls == CLS_TWO || out_a2 == '0) &&
                    (out_cls != CLS_ZERO || out_a1 == '0))));
  // R9: a decoded word tagged three-address never had the escape on top
  a_r9_prefix_free: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[4*NIB_W-1 -: NIB_W] == {NIB_W{1'b1}})
      |=> (out_cls != CLS_THREE));
endmodule

// File: tb/tb_xop_decoder.sv
module tb_xop_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_word;
  logic        out_valid;
  logic [1:0]  out_cls;
  logic [5:0]  out_op;
  logic [3:0]  out_a1, out_a2, out_a3;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int tally [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  xop_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_cls(out_cls), .out_op(out_op),
    .out_a1(out_a1), .out_a2(out_a2), .out_a3(out_a3)
  );

  // Expected decode written straight from the requirement text.
  function automatic void model(input logic [15:0] w, output logic [1:0] c,
                                output logic [5:0] op, output logic [3:0] x1,
                                output logic [3:0] x2, output logic [3:0] x3,
                                output string tag);
    int hi = w[15:12];
    int b2 = w[11:8];
    int b1 = w[7:4];
    int b0 = w[3:0];
    x1 = 0; x2 = 0; x3 = 0;
    if (hi <= 14) begin
      c = 0; op = 6'(hi); x1 = 4'(b2); x2 = 4'(b1); x3 = 4'(b0); tag = "R1";
    end else if (b2 <= 11) begin
      c = 1; op = 6'(b2); x1 = 4'(b1); x2 = 4'(b0); tag = "R2";
    end else if (b2 <= 14) begin
      c = 2; op = 6'((b2 - 12) * 16 + b1); x1 = 4'(b0); tag = "R3";
    end else if (b1 <= 13) begin
      c = 2; op = 6'(48 + b1); x1 = 4'(b0); tag = "R4";
    end else begin
      c = 3; op = 6'((b1 - 14) * 16 + b0); tag = "R5";
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [15:0] w);
    logic [1:0] c; logic [5:0] op; logic [3:0] x1, x2, x3; string tag;
    model(w, c, op, x1, x2, x3, tag);
    check(tag, $sformatf("class w=%h", w), out_cls, c);
    check(tag, $sformatf("opcode w=%h", w), out_op, op);
    check(tag, $sformatf("addr1 w=%h", w), out_a1, x1);
    // R6: unused fields read zero, encoded in the model
    check("R6", $sformatf("addr2 w=%h", w), out_a2, x2);
    check("R6", $sformatf("addr3 w=%h", w), out_a3, x3);
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", "out_valid after strobe", out_valid, 1);
    check_outputs(w);
    tally[out_cls]++;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] corner [12];
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_word  = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "out_valid in reset", out_valid, 0);
    check("R8", "class in reset", out_cls, 0);
    check("R8", "opcode in reset", out_op, 0);
    check("R8", "addr in reset", {out_a1, out_a2, out_a3}, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "idle out_valid", out_valid, 0);

    // Directed corners at every escape boundary
    corner = '{16'h0123, 16'hE9AB, 16'hF000, 16'hFB5A, 16'hFC07,
               16'hFEF3, 16'hFF0C, 16'hFFD1, 16'hFFE0, 16'hFFEF,
               16'hFFF0, 16'hFFFF};
    foreach (corner[i]) apply(corner[i]);
    for (int i = 0; i < 4; i++) tally[i] = 0;

    // R9: exhaustive sweep and class tallies
    for (int w = 0; w < 65536; w++) apply(16'(w));
    check("R9", "three-address count", tally[0], 61440);
    check("R9", "two-address count", tally[1], 3072);
    check("R9", "one-address count", tally[2], 992);
    check("R9", "zero-address count", tally[3], 32);

    // Class-biased random words
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] w = 16'($urandom);
      case ($urandom_range(0, 3))
        0: w[15:12] = 4'($urandom_range(0, 14));
        1: begin w[15:12] = 4'hF; w[11:8] = 4'($urandom_range(0, 11)); end
        2: begin w[15:8] = 8'hFF; w[7:4] = 4'($urandom_range(0, 13)); end
        default: w[15:5] = '1;
      endcase
      apply(w);
    end

    // R7: no strobe means outputs hold while the input changes
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w = 16'($urandom);
      apply(w);
      in_word = ~w;
      @(negedge clk);
      check("R7", "out_valid without strobe", out_valid, 0);
      check_outputs(w);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule